// File: doc/BRIEF.md
# Slow-Write Slot Store Controller

This block holds a small bank of 8-bit settings slots, four per wiper channel, and treats every change to them as a slow, deferred write. The command decoder hands it a store-changing request once the data or command byte has been acknowledged. The request can be a direct slot write, a copy of one channel's current wiper value into a slot, or a copy of every channel's wiper value into the same-numbered slot. The request waits in a pending buffer. A clean stop condition launches a timed internal write window. A new start condition that comes first throws the request away.

While the window runs, `busy` is high. The bus front end uses it to withhold the acknowledge on its own slave address, so a master can poll with address-only transfers until the device answers again. Reads are refused the same way. A hardware protect input, active low, blocks every store-changing request at the moment it is offered. A blocked request still completes normally on the bus but opens no window. Slot 0 of each channel is driven out continuously as the value that the wiper loads at power-up.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset `busy` is low and every slot of every channel holds 8'h80.
- R2: `req_op` code 0 writes `req_data`, code 1 copies channel `req_chan`'s wiper, and code 2 copies all wipers. `req_slot` selects the slot (0..3) and `req_chan` selects the channel (0..1). A stop pulse with a request pending raises `busy` from the next cycle for exactly `WR_CYCLES` cycles.
- R3: During the window the addressed slot still reads its old value. The new value is readable in the first cycle in which `busy` is low again.
- R4: A start pulse that arrives after a request and before its stop discards the request: no window opens and no slot changes.
- R5: A request offered while `wp_n` is low is dropped: no window opens and no slot changes, even if `wp_n` has returned high by the stop.
- R6: A copy request (code 1) stores the wiper value that was present at the request cycle, not the value present at the stop.
- R7: A global copy (code 2) writes each channel's wiper into the same-numbered slot, within one window.
- R8: Requests, start pulses and stop pulses that arrive while `busy` is high have no effect on any slot and open no further window.
- R9: `recall_out[8c+7:8c]` always equals slot 0 of channel c.
- R10: A stop with nothing pending, or after a request with code 3, opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| wp_n | input | 1 | Store protect, low blocks store changes |
| req_valid | input | 1 | One-cycle request strobe from the command decoder |
| req_op | input | 2 | Request code: 0 write, 1 wiper copy, 2 global copy, 3 none |
| req_chan | input | 1 | Target channel |
| req_slot | input | 2 | Target slot |
| req_data | input | 8 | Data for a direct write |
| wiper_in | input | 16 | Current wiper values, channel c at [8c+7:8c] |
| bus_start | input | 1 | One-cycle pulse on a start condition |
| bus_stop | input | 1 | One-cycle pulse on a valid stop condition |
| rd_chan | input | 1 | Read channel select |
| rd_slot | input | 2 | Read slot select |
| rd_data | output | 8 | Contents of the selected slot |
| recall_out | output | 16 | Slot 0 of each channel for power-up recall |
| busy | output | 1 | Write window active; address acknowledge must be withheld |

## Verification
A pending buffer left stale or wrongly cleared shows up at the first stop after it. The result is either a window that should not exist or a missing one, visible on `busy` one cycle after the stop pulse. A wrong window counter shows up as a `busy` run length other than `WR_CYCLES`, and the run length is measured on every window. A wrong commit target or commit time shows up on a read of the target slot, or on `recall_out`, either during the window or in the first idle cycle after it.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int DW    = 8;
    localparam int NCH   = 2;
    localparam int NSLOT = 4;
    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [DW-1:0] INIT_WORD = 8'h80;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_W2S   = 2'd1,
        OP_GW2S  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef struct packed {
        logic                     valid;
        logic                     global;
        logic [CW-1:0]            chan;
        logic [SW-1:0]            slot;
        logic [NCH-1:0][DW-1:0]   word;
    } pend_t;

    function automatic logic op_changes_store(op_e op);
        return op != OP_NONE;
    endfunction
endpackage

// File: rtl/nvs_pending.sv
module nvs_pending
    import nvs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [CW-1:0]       req_chan,
    input  logic [SW-1:0]       req_slot,
    input  logic [DW-1:0]       req_data,
    input  logic [NCH*DW-1:0]   wiper_in,
    input  logic                wp_n,
    input  logic                bus_start,
    input  logic                locked,
    input  logic                clear,
    output pend_t               pend
);
    op_e   op;
    logic  accept;
    pend_t nxt;

    assign op     = op_e'(req_op);
    assign accept = req_valid && wp_n && op_changes_store(op) && !locked;

    always_comb begin
        nxt        = '0;
        nxt.valid  = 1'b1;
        nxt.global = (op == OP_GW2S);
        nxt.chan   = req_chan;
        nxt.slot   = req_slot;
    end

    pend_t cap;
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_word
            assign cap.word[c] = (op == OP_WRITE) ? req_data : wiper_in[c*DW +: DW];
        end
    endgenerate
    assign cap.valid  = nxt.valid;
    assign cap.global = nxt.global;
    assign cap.chan   = nxt.chan;
    assign cap.slot   = nxt.slot;

    always_ff @(posedge clk) begin
        if (rst)                      pend <= '0;
        else if (clear)               pend <= '0;
        else if (accept)              pend <= cap;
        else if (bus_start && !locked) pend <= '0;
    end

    // R5
    wp_blocks_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !wp_n && !bus_start && !clear) |=> $stable(pend.valid));

    // R8
    locked_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !clear) |=> $stable(pend));
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CNTW = $clog2(CYCLES + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(CYCLES - 1);
    localparam logic [CNTW-1:0] LIM  = CNTW'(CYCLES);

    logic [CNTW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    // R2
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < LIM));
endmodule

// File: rtl/nvs_array.sv
module nvs_array
    import nvs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  pend_t               pend,
    input  logic [CW-1:0]       rd_chan,
    input  logic [SW-1:0]       rd_slot,
    output logic [DW-1:0]       rd_data,
    output logic [NCH*DW-1:0]   recall_out
);
    logic [DW-1:0] chan_rd [NCH];

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chan
            logic [DW-1:0] slots [NSLOT];
            logic          hit;
            assign hit = commit && (pend.global || (pend.chan == CW'(c)));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < NSLOT; s++) slots[s] <= INIT_WORD;
                end else if (hit) begin
                    slots[pend.slot] <= pend.word[c];
                end
            end

            assign chan_rd[c]              = slots[rd_slot];
            assign recall_out[c*DW +: DW]  = slots[0];
        end
    endgenerate

    assign rd_data = chan_rd[rd_chan];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int WR_CYCLES = 500000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wp_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [CW-1:0]       req_chan,
    input  logic [SW-1:0]       req_slot,
    input  logic [DW-1:0]       req_data,
    input  logic [NCH*DW-1:0]   wiper_in,
    input  logic                bus_start,
    input  logic                bus_stop,
    input  logic [CW-1:0]       rd_chan,
    input  logic [SW-1:0]       rd_slot,
    output logic [DW-1:0]       rd_data,
    output logic [NCH*DW-1:0]   recall_out,
    output logic                busy
);
    pend_t pend;
    logic  done;
    logic  launch;

    assign launch = bus_stop && pend.valid && !busy;

    nvs_pending u_pend (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_chan(req_chan), .req_slot(req_slot), .req_data(req_data),
        .wiper_in(wiper_in), .wp_n(wp_n), .bus_start(bus_start),
        .locked(busy), .clear(done), .pend(pend)
    );

    nvs_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .launch(launch), .busy(busy), .done(done)
    );

    nvs_array u_arr (
        .clk(clk), .rst(rst), .commit(done), .pend(pend),
        .rd_chan(rd_chan), .rd_slot(rd_slot), .rd_data(rd_data),
        .recall_out(recall_out)
    );

    // R2
    stop_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    // R2
    window_end_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !pend.valid);

    // R3
    store_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(recall_out));

    // R10
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stop && !pend.valid && !busy) |=> !busy);
endmodule

// File: tb/tb_nvs_ctrl.sv
module tb_nvs_ctrl;
    localparam int W = 40;

    logic        clk = 0;
    logic        rst = 1;
    logic        wp_n = 1;
    logic        req_valid = 0;
    logic [1:0]  req_op = 0;
    logic [0:0]  req_chan = 0;
    logic [1:0]  req_slot = 0;
    logic [7:0]  req_data = 0;
    logic [15:0] wiper_in = 0;
    logic        bus_start = 0;
    logic        bus_stop = 0;
    logic [0:0]  rd_chan = 0;
    logic [1:0]  rd_slot = 0;
    logic [7:0]  rd_data;
    logic [15:0] recall_out;
    logic        busy;

    nvs_ctrl #(.WR_CYCLES(W)) dut (
        .clk(clk), .rst(rst), .wp_n(wp_n), .req_valid(req_valid), .req_op(req_op),
        .req_chan(req_chan), .req_slot(req_slot), .req_data(req_data),
        .wiper_in(wiper_in), .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_chan(rd_chan), .rd_slot(rd_slot), .rd_data(rd_data),
        .recall_out(recall_out), .busy(busy)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] model [2][4];
    int exp_q[$];
    int run = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: measures every busy run and pops the expected window length
    always @(negedge clk) begin
        if (rst) run = 0;
        else if (busy) run++;
        else if (run != 0) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected window", run, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(run == e, "R2 window length", run, e);
            end
            run = 0;
        end
    end

    task automatic pulse_req(input logic [1:0] op, input int ch, input int sl, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_op = op; req_chan = ch[0:0]; req_slot = sl[1:0]; req_data = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1;
        @(negedge clk); bus_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic rd(input int ch, input int sl, output logic [7:0] v);
        rd_chan = ch[0:0]; rd_slot = sl[1:0];
        #1 v = rd_data;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++) begin
                rd(c, s, v);
                chk(v == model[c][s], req, v, model[c][s]);
            end
        chk(recall_out == {model[1][0], model[0][0]}, "R9 recall", recall_out,
            {model[1][0], model[0][0]});
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < W + 10) begin @(negedge clk); n++; end
        chk(!busy, "R2 window ends", busy, 0);
    endtask

    // Opens a window for the pending request, checks old data during it
    task automatic commit_window(input int ch, input int sl);
        logic [7:0] v;
        exp_q.push_back(W);
        pulse_stop();
        chk(busy == 1, "R2 busy after stop", busy, 1);
        rd(ch, sl, v);
        chk(v == model[ch][sl], "R3 old value during window", v, model[ch][sl]);
    endtask

    task automatic expect_no_window(input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy == 0, req, busy, 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 2; c++) for (int s = 0; s < 4; s++) model[c][s] = 8'h80;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        check_all("R1 reset contents");

        // R2 R3: direct write channel 0 slot 2
        pulse_req(2'd0, 0, 2, 8'h3C);
        commit_window(0, 2);
        wait_idle();
        model[0][2] = 8'h3C;
        check_all("R3 new value after window");

        // R9: write slot 0 of channel 1 drives recall
        pulse_req(2'd0, 1, 0, 8'hA5);
        commit_window(1, 0);
        wait_idle();
        model[1][0] = 8'hA5;
        check_all("R9 slot0 recall");

        // R4: start before stop discards
        pulse_req(2'd0, 0, 3, 8'h77);
        pulse_start();
        pulse_stop();
        expect_no_window("R4 no window after abort");
        check_all("R4 contents unchanged");

        // R5: protected request dropped even if protect lifts before stop
        wp_n = 0;
        pulse_req(2'd0, 1, 1, 8'h99);
        wp_n = 1;
        pulse_stop();
        expect_no_window("R5 no window when protected");
        check_all("R5 contents unchanged");

        // R6: wiper copy captures value at request
        wiper_in = {8'h11, 8'h22};
        pulse_req(2'd1, 1, 3, 8'h00);
        wiper_in = {8'hEE, 8'hDD};
        commit_window(1, 3);
        wait_idle();
        model[1][3] = 8'h11;
        check_all("R6 wiper copy");

        // R7 + R8: global copy, with traffic during its window
        wiper_in = {8'hC3, 8'h5A};
        pulse_req(2'd2, 0, 1, 8'h00);
        commit_window(0, 1);
        pulse_req(2'd0, 0, 1, 8'hFF);
        pulse_start();
        pulse_req(2'd0, 1, 2, 8'hFE);
        pulse_stop();
        wait_idle();
        model[0][1] = 8'h5A;
        model[1][1] = 8'hC3;
        check_all("R7 global copy / R8 busy traffic ignored");
        pulse_stop();
        expect_no_window("R8 no window from busy-time request");

        // R10: stop with nothing pending, and code 3
        pulse_stop();
        expect_no_window("R10 idle stop");
        pulse_req(2'd3, 0, 0, 8'h01);
        pulse_stop();
        expect_no_window("R10 code 3");
        check_all("R10 contents unchanged");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all windows seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule